// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every cause that can restart a small microcontroller core and merges them into one internal chip reset. The causes are the power-on detector, an active-low external reset pin behind a glitch filter, the watchdog time-out, the brown-out detector, the software reset instruction, and the stack overflow and underflow traps. Any of them sets a latch that holds `chip_rst_o` high. The latch clears only after the causes have gone away and the enabled start-up delays have run out. These delays are a power-up timer that counts slow internal ticks, followed by an oscillator start-up timer that counts main-clock cycles.

The block treats a watchdog time-out that arrives while the core is asleep or idle as a wake-up, not a reset, and reports it on `wake_o`. Five sticky status flags record what happened, so firmware can tell the causes apart. The flags are active-low, as in the usual convention for this kind of controller: a 0 marks that the event occurred. The only way to write them is a write-ones-to-set strobe, which firmware uses to re-arm them. The pin is observed only and never driven. Analog detection arrives already as digital levels. `por_in` also acts as the asynchronous reset of every register in the block.

Top module: `reset_sequencer`

## Requirements
- R1: While any of these is active, `chip_rst_o` is 1 from the next clock edge on: `por_in`, a recognised pin reset, `wdt_to` with `sleeping`=0, `bor_det` with `bor_en`=1, `reset_instr`, `stk_full`, `stk_under`.
- R2: `ext_rst_n` is sampled only on cycles with `slow_tick`=1. A pin reset is recognised after FILT_SAMPLES (default 4) consecutive low samples. A high sample restarts the count, so shorter lows never cause a reset.
- R3: With `ext_en`=0 the pin is ignored completely.
- R4: With `bor_en`=0, `bor_det` has no effect on `chip_rst_o` or on the flags.
- R5: `wdt_to` with `sleeping`=1 leaves `chip_rst_o` low and gives `wake_o`=1 on the following cycle.
- R6: With `pwrt_en`=0 and `ost_en`=0, `chip_rst_o` falls one clock edge after the last cause goes away.
- R7: With only `ost_en`=1, `chip_rst_o` falls 1+OST_CYCLES edges after the last cause goes away.
- R8: With both timers enabled, the power-up timer first counts PWRT_TICKS slow ticks, then the start-up timer counts OST_CYCLES clocks, and then `chip_rst_o` falls.
- R9: A new cause during the delay returns the sequencer to hold, and the delay restarts in full once that cause goes away.
- R10: `stat_o` bit map: [4] no reset instruction, [3] no watchdog time-out, [2] not powered down, [1] no power-on, [0] no brown-out. `por_in` forces `stat_o`=5'b11100.
- R11: Flag updates by cause:
  - enabled brown-out sets [4:2] and clears [0];
  - watchdog while awake clears [3] and sets [2];
  - watchdog while asleep clears [3:2];
  - pin reset while asleep sets [3] and clears [2];
  - reset instruction clears [4];
  - a pin reset while awake, or a stack trap, leaves all flags unchanged.
- R12: Each 1 in `flag_set` sets the matching bit of `stat_o` on the next edge, unless an R11 update writes that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_in | input | 1 | Power-on detect, active high, asynchronous |
| slow_tick | input | 1 | One-cycle pulse from the slow internal oscillator |
| ext_rst_n | input | 1 | External reset pin, active low |
| ext_en | input | 1 | Enables the external pin path |
| sleeping | input | 1 | Core is in sleep or idle |
| wdt_to | input | 1 | Watchdog time-out |
| bor_det | input | 1 | Brown-out detected |
| bor_en | input | 1 | Brown-out reset enable |
| reset_instr | input | 1 | Software reset instruction executed |
| stk_full | input | 1 | Stack overflow trap |
| stk_under | input | 1 | Stack underflow trap |
| pwrt_en | input | 1 | Use the power-up timer |
| ost_en | input | 1 | Use the oscillator start-up timer |
| flag_set | input | 5 | Write-ones-to-set strobe for the flags |
| chip_rst_o | output | 1 | Internal chip reset |
| wake_o | output | 1 | Watchdog wake-up pulse |
| stat_o | output | 5 | Sticky active-low cause flags |

## Verification
The sequencer state shows directly on `chip_rst_o`. A state that is stuck or skips a phase shows as a release edge that comes early or late, measured in cycles from the moment the last cause goes away. The bench pins this edge to the exact cycle in the start-up-timer-only and timer-free cases, and to one tick window when the power-up timer is enabled. A filter count that is wrong shows as a reset after a glitch, or as a missing reset after a long low. A wrong flag update shows on `stat_o` one cycle after the cause.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {SQ_HOLD, SQ_PWRT, SQ_OST, SQ_RUN} seq_state_e;
  localparam int FL_INSTR = 4;
  localparam int FL_WDOG  = 3;
  localparam int FL_AWAKE = 2;
  localparam int FL_PWRON = 1;
  localparam int FL_BROWN = 0;
  localparam int FL_W     = 5;
endpackage

// File: rtl/rs_pin_filter.sv
module rs_pin_filter #(
  parameter int FILT_SAMPLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin_n,
  input  logic en,
  output logic pin_rst
);
  localparam int CW = $clog2(FILT_SAMPLES + 1);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      low_cnt <= '0;
      pin_rst <= 1'b0;
    end else if (!en) begin
      low_cnt <= '0;
      pin_rst <= 1'b0;
    end else if (tick) begin
      if (pin_n) begin
        low_cnt <= '0;
        pin_rst <= 1'b0;
      end else if (low_cnt == CW'(FILT_SAMPLES - 1) || pin_rst) begin
        low_cnt <= CW'(FILT_SAMPLES);
        pin_rst <= 1'b1;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  // R3
  pin_off_chk: assert property (@(posedge clk) disable iff (rst) !en |=> !pin_rst);
  // R2
  pin_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(pin_rst) |-> $past(!pin_n && tick));
endmodule

// File: rtl/rs_delay_timer.sv
module rs_delay_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic step,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (step)           cnt <= (cnt == CW'(LIMIT - 1)) ? '0 : cnt + 1'b1;
  end

  assign done = run && step && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/rs_cause_flags.sv
module rs_cause_flags
  import rst_seq_pkg::*;
(
  input  logic            clk,
  input  logic            por,
  input  logic            bor_evt,
  input  logic            wdt_awake,
  input  logic            wdt_sleep,
  input  logic            pin_sleep,
  input  logic            instr,
  input  logic [FL_W-1:0] set_mask,
  output logic [FL_W-1:0] stat
);
  logic [FL_W-1:0] nxt;

  always_comb begin
    nxt = stat | set_mask;
    if (instr) nxt[FL_INSTR] = 1'b0;
    if (pin_sleep) begin
      nxt[FL_WDOG]  = 1'b1;
      nxt[FL_AWAKE] = 1'b0;
    end
    if (wdt_sleep) begin
      nxt[FL_WDOG]  = 1'b0;
      nxt[FL_AWAKE] = 1'b0;
    end
    if (wdt_awake) begin
      nxt[FL_WDOG]  = 1'b0;
      nxt[FL_AWAKE] = 1'b1;
    end
    if (bor_evt) begin
      nxt[FL_INSTR] = 1'b1;
      nxt[FL_WDOG]  = 1'b1;
      nxt[FL_AWAKE] = 1'b1;
      nxt[FL_BROWN] = 1'b0;
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) stat <= 5'b11100;
    else     stat <= nxt;
  end

  // R11
  instr_flag_chk: assert property (@(posedge clk) disable iff (por)
    $past(instr && !bor_evt) |-> !stat[FL_INSTR]);
  // R11
  brown_flag_chk: assert property (@(posedge clk) disable iff (por)
    $past(bor_evt) |-> !stat[FL_BROWN]);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int FILT_SAMPLES = 4,
  parameter int PWRT_TICKS   = 2048,
  parameter int OST_CYCLES   = 1024
) (
  input  logic       clk,
  input  logic       por_in,
  input  logic       slow_tick,
  input  logic       ext_rst_n,
  input  logic       ext_en,
  input  logic       sleeping,
  input  logic       wdt_to,
  input  logic       bor_det,
  input  logic       bor_en,
  input  logic       reset_instr,
  input  logic       stk_full,
  input  logic       stk_under,
  input  logic       pwrt_en,
  input  logic       ost_en,
  input  logic [4:0] flag_set,
  output logic       chip_rst_o,
  output logic       wake_o,
  output logic [4:0] stat_o
);
  seq_state_e state, state_nx;
  logic pin_rst, pwrt_done, ost_done, src_any, bor_evt, wdt_awake, wdt_sleep;

  rs_pin_filter #(.FILT_SAMPLES(FILT_SAMPLES)) u_filt (
    .clk(clk), .rst(por_in), .tick(slow_tick), .pin_n(ext_rst_n),
    .en(ext_en), .pin_rst(pin_rst));

  rs_delay_timer #(.LIMIT(PWRT_TICKS)) u_pwrt (
    .clk(clk), .rst(por_in), .run(state == SQ_PWRT), .step(slow_tick),
    .done(pwrt_done));

  rs_delay_timer #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(clk), .rst(por_in), .run(state == SQ_OST), .step(1'b1),
    .done(ost_done));

  assign bor_evt   = bor_det && bor_en;
  assign wdt_awake = wdt_to && !sleeping;
  assign wdt_sleep = wdt_to && sleeping;
  assign src_any   = pin_rst || wdt_awake || bor_evt || reset_instr ||
                     stk_full || stk_under;

  rs_cause_flags u_flags (
    .clk(clk), .por(por_in), .bor_evt(bor_evt), .wdt_awake(wdt_awake),
    .wdt_sleep(wdt_sleep), .pin_sleep(pin_rst && sleeping),
    .instr(reset_instr), .set_mask(flag_set), .stat(stat_o));

  always_comb begin
    state_nx = state;
    if (src_any) state_nx = SQ_HOLD;
    else begin
      case (state)
        SQ_HOLD: state_nx = pwrt_en ? SQ_PWRT : (ost_en ? SQ_OST : SQ_RUN);
        SQ_PWRT: if (pwrt_done) state_nx = ost_en ? SQ_OST : SQ_RUN;
        SQ_OST:  if (ost_done) state_nx = SQ_RUN;
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por_in) begin
    if (por_in) begin
      state  <= SQ_HOLD;
      wake_o <= 1'b0;
    end else begin
      state  <= state_nx;
      wake_o <= wdt_sleep;
    end
  end

  assign chip_rst_o = (state != SQ_RUN);

  // R1
  src_hold_chk: assert property (@(posedge clk) disable iff (por_in) src_any |=> chip_rst_o);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (por_in) $fell(chip_rst_o) |-> $past(!src_any));
  // R5
  wake_no_rst_chk: assert property (@(posedge clk) disable iff (por_in)
    (!chip_rst_o && wdt_sleep && !src_any) |=> (!chip_rst_o && wake_o));
endmodule

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
  localparam int PT = 8, OC = 16;
  logic clk = 0, por_in = 1, slow_tick = 0, ext_rst_n = 1, ext_en = 1, sleeping = 0;
  logic wdt_to = 0, bor_det = 0, bor_en = 0, reset_instr = 0, stk_full = 0, stk_under = 0;
  logic pwrt_en = 1, ost_en = 1;
  logic [4:0] flag_set = 0;
  logic chip_rst_o, wake_o;
  logic [4:0] stat_o;
  logic [1:0] divc = 0;
  int checks = 0, fails = 0;
  bit seen;

  always #5 clk = ~clk;
  always @(negedge clk) begin divc <= divc + 1'b1; slow_tick <= (divc == 2'd3); end

  reset_sequencer #(.FILT_SAMPLES(4), .PWRT_TICKS(PT), .OST_CYCLES(OC)) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic set_all_flags();
    flag_set = 5'b11111; cyc(1); flag_set = 0; cyc(1);
  endtask

  task automatic t_por();
    int n;
    cyc(3);
    chk(chip_rst_o, "R1 por", chip_rst_o, 1);
    chk(stat_o == 5'b11100, "R10 por flags", stat_o, 5'b11100);
    por_in = 0; n = 0;
    while (chip_rst_o && n < 200) begin cyc(1); n++; end
    chk(n >= (PT-1)*4+1+OC && n <= PT*4+1+OC, "R8 pwrt+ost release", n, PT*4+1+OC);
  endtask

  task automatic t_flag_set();
    flag_set = 5'b00011; cyc(1); flag_set = 0;
    chk(stat_o == 5'b11111, "R12 set", stat_o, 5'b11111);
  endtask

  task automatic t_instr();
    pwrt_en = 0; ost_en = 0;
    reset_instr = 1; cyc(1);
    chk(chip_rst_o, "R1 instr", chip_rst_o, 1);
    chk(stat_o == 5'b01111, "R11 instr flag", stat_o, 5'b01111);
    reset_instr = 0; cyc(1);
    chk(!chip_rst_o, "R6 no timers", chip_rst_o, 0);
  endtask

  task automatic t_stack();
    int n;
    set_all_flags(); ost_en = 1;
    stk_under = 1; cyc(1); stk_under = 0; cyc(16);
    chk(chip_rst_o, "R7 ost still held", chip_rst_o, 1);
    cyc(1);
    chk(!chip_rst_o, "R7 ost release", chip_rst_o, 0);
    stk_full = 1; cyc(1);
    chk(chip_rst_o, "R1 stk_full", chip_rst_o, 1);
    stk_full = 0; cyc(17);
    chk(stat_o == 5'b11111, "R11 stack no flag", stat_o, 5'b11111);
  endtask

  task automatic t_restart();
    int n;
    reset_instr = 1; cyc(1); reset_instr = 0; cyc(8);
    stk_full = 1; cyc(2); stk_full = 0; n = 0;
    while (chip_rst_o && n < 100) begin cyc(1); n++; end
    chk(n == OC + 1, "R9 restart", n, OC + 1);
    ost_en = 0;
  endtask

  task automatic t_wdt();
    set_all_flags();
    wdt_to = 1; cyc(1); wdt_to = 0;
    chk(chip_rst_o, "R1 wdt awake", chip_rst_o, 1);
    chk(stat_o == 5'b10111, "R11 wdt awake", stat_o, 5'b10111);
    cyc(2); set_all_flags();
    sleeping = 1; wdt_to = 1; cyc(1); wdt_to = 0;
    chk(!chip_rst_o, "R5 no reset", chip_rst_o, 0);
    chk(wake_o, "R5 wake", wake_o, 1);
    chk(stat_o == 5'b10011, "R11 wdt sleep", stat_o, 5'b10011);
    sleeping = 0; cyc(1);
  endtask

  task automatic t_bor();
    set_all_flags();
    bor_en = 0; bor_det = 1; seen = 0;
    repeat (5) begin cyc(1); if (chip_rst_o) seen = 1; end
    bor_det = 0;
    chk(!seen, "R4 bor disabled", seen, 0);
    chk(stat_o == 5'b11111, "R4 bor flags", stat_o, 5'b11111);
    bor_en = 1; bor_det = 1; cyc(1); bor_det = 0;
    chk(chip_rst_o, "R1 bor", chip_rst_o, 1);
    chk(stat_o == 5'b11110, "R11 bor", stat_o, 5'b11110);
    cyc(2);
  endtask

  task automatic t_pin();
    seen = 0;
    ext_rst_n = 0; repeat (10) begin cyc(1); if (chip_rst_o) seen = 1; end
    ext_rst_n = 1; cyc(4);
    ext_rst_n = 0; repeat (10) begin cyc(1); if (chip_rst_o) seen = 1; end
    ext_rst_n = 1; cyc(6);
    chk(!seen, "R2 glitch rejected", seen, 0);
    set_all_flags(); sleeping = 1;
    ext_rst_n = 0; cyc(30);
    chk(chip_rst_o, "R2 long low", chip_rst_o, 1);
    ext_rst_n = 1; sleeping = 0; cyc(8);
    chk(stat_o == 5'b11011, "R11 pin sleep", stat_o, 5'b11011);
    ext_en = 0; ext_rst_n = 0; seen = 0;
    repeat (40) begin cyc(1); if (chip_rst_o) seen = 1; end
    ext_rst_n = 1;
    chk(!seen, "R3 pin disabled", seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_por(); t_flag_set(); t_instr(); t_stack(); t_restart();
    t_wdt(); t_bor(); t_pin();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule